// File: doc/BRIEF.md
# Variable-Step Stack Pointer Unit

This block keeps the 16-bit stack pointer for a byte-addressed data memory and produces the address, the read and write strokes, and the byte-lane order for every stack access. The stack grows toward lower addresses. Single-byte data pushes and pops move the pointer by one. Saving a return address on a call or interrupt, and restoring it on a return, move the pointer by two. The two-byte transfers are split into two memory beats, and the block tells the memory side which half of the return address each beat carries. The memory array and the program counter are outside the block.

Software sees the pointer as two 8-bit halves and writes each one on its own. No initial value is useful: the pointer resets to zero and has to be loaded before the stack is used. In a typical system it is set near the top of the data space, for example 0x085F, with SRAM starting at 0x0060. All arithmetic wraps modulo 2^16 and raises no error.

Top module: `stack_ptr_unit`

## Requirements
- R1: After synchronous reset, sp_o is 0x0000, busy_o is 0, and neither mem_we_o nor mem_re_o is asserted.
- R2: An accepted push asserts mem_we_o in that same cycle, with addr_o equal to the current pointer and lane_hi_o at 0. After the clock edge, the pointer has dropped by 1.
- R3: An accepted pop asserts mem_re_o in that same cycle, with addr_o equal to the pointer plus 1 and lane_hi_o at 0. After the clock edge, the pointer has risen by 1.
- R4: An accepted call runs two beats. Beat 0 (busy_o=0) writes at the pointer with lane_hi_o=0 for the low byte. Beat 1 (busy_o=1) writes at the pointer minus 1 with lane_hi_o=1 for the high byte. After beat 1 the pointer has dropped by 2.
- R5: An accepted return runs two beats. Beat 0 (busy_o=0) reads at the pointer plus 1 with lane_hi_o=1 for the high byte. Beat 1 (busy_o=1) reads at the pointer plus 2 with lane_hi_o=0 for the low byte. After beat 1 the pointer has risen by 2.
- R6: When more than one strobe is high in an idle cycle, only one operation is accepted. The order of precedence is call, then return, then push, then pop.
- R7: Any push, pop, call or return strobe that arrives during beat 1 (busy_o=1) is ignored. It has no effect on the accesses or on the pointer.
- R8: wr_hi_i loads wr_data_i into pointer bits [15:8] and wr_lo_i loads it into bits [7:0]. If only one enable is high, the other half keeps its value. If both are high, both halves take the same byte.
- R9: A half write has priority over the stack operation in the same cycle. In an idle cycle, a strobe that comes with a write is dropped and no access is made. In beat 1, the access is still made, the written half takes wr_data_i, and the unwritten half takes its part of the stepped pointer.
- R10: Pointer arithmetic wraps modulo 2^16. A push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF reads address 0x0000.
- R11: In an idle cycle with no accepted operation, addr_o equals sp_o, lane_hi_o is 0, and mem_we_o and mem_re_o are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Single-byte push strobe |
| pop_i | input | 1 | Single-byte pop strobe |
| call_i | input | 1 | Return-address save strobe (call or interrupt) |
| ret_i | input | 1 | Return-address restore strobe |
| wr_hi_i | input | 1 | Load the upper pointer byte |
| wr_lo_i | input | 1 | Load the lower pointer byte |
| wr_data_i | input | 8 | Byte for the pointer half writes |
| sp_o | output | 16 | Current stack pointer |
| addr_o | output | 16 | Memory address for this cycle's access |
| mem_we_o | output | 1 | Memory write stroke |
| mem_re_o | output | 1 | Memory read stroke |
| lane_hi_o | output | 1 | Beat carries the high byte of a return address |
| busy_o | output | 1 | Second beat of a two-byte transfer |

## Verification
Directed cases load the pointer near the top of SRAM. They then run each operation alone, which separates the step of one from the step of two and the pre-decrement address from the post-increment address. Cycles that raise several strobes together check the precedence order. Strobes raised during a second beat show that the sequencer does not restart. Half writes that coincide with an idle strobe, and half writes that land in a second beat, separate the two cases of write precedence. The runs at 0x0000 and 0xFFFF show the wrap. Several thousand seeded random cycles then mix all strobes with occasional half writes, and every cycle is compared with a bench model.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PTR_W  = 2 * BYTE_W;

    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_RET
    } op_e;

    typedef struct packed {
        ptr_t addr;
        logic we;
        logic re;
        logic lane_hi;
    } acc_t;

    // move a pointer by one or two bytes, down or up, wrapping
    function automatic ptr_t sp_step(ptr_t p, logic down, logic two);
        ptr_t d;
        d = two ? ptr_t'(2) : ptr_t'(1);
        return down ? ptr_t'(p - d) : ptr_t'(p + d);
    endfunction
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
    import sp_pkg::*;
(
    input  logic push,
    input  logic pop,
    input  logic call,
    input  logic ret,
    input  logic busy,
    input  logic wr_any,
    output op_e  op
);
    // fixed precedence; nothing starts in beat 1 or under a half write
    always_comb begin
        op = OP_NONE;
        if (!busy && !wr_any) begin
            if (call)      op = OP_CALL;
            else if (ret)  op = OP_RET;
            else if (push) op = OP_PUSH;
            else if (pop)  op = OP_POP;
        end
    end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
    import sp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output logic busy,
    output logic is_save
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            is_save <= 1'b0;
        end else begin
            busy    <= (op == OP_CALL) || (op == OP_RET);
            is_save <= (op == OP_CALL);
        end
    end
endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
    import sp_pkg::*;
(
    input  op_e  op,
    input  logic busy,
    input  logic is_save,
    input  ptr_t sp,
    output acc_t acc,
    output logic upd,
    output ptr_t upd_val
);
    always_comb begin
        acc     = '{addr: sp, we: 1'b0, re: 1'b0, lane_hi: 1'b0};
        upd     = 1'b0;
        upd_val = sp;
        if (busy) begin
            upd     = 1'b1;
            upd_val = sp_step(sp, is_save, 1'b1);
            if (is_save) begin
                acc.addr    = sp_step(sp, 1'b1, 1'b0);
                acc.we      = 1'b1;
                acc.lane_hi = 1'b1;
            end else begin
                acc.addr = sp_step(sp, 1'b0, 1'b1);
                acc.re   = 1'b1;
            end
        end else begin
            unique case (op)
                OP_PUSH: begin
                    acc.we  = 1'b1;
                    upd     = 1'b1;
                    upd_val = sp_step(sp, 1'b1, 1'b0);
                end
                OP_POP: begin
                    acc.addr = sp_step(sp, 1'b0, 1'b0);
                    acc.re   = 1'b1;
                    upd      = 1'b1;
                    upd_val  = acc.addr;
                end
                OP_CALL: begin
                    acc.we = 1'b1;
                end
                OP_RET: begin
                    acc.addr    = sp_step(sp, 1'b0, 1'b0);
                    acc.re      = 1'b1;
                    acc.lane_hi = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg
    import sp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_hi,
    input  logic  wr_lo,
    input  byte_t wr_data,
    input  logic  upd,
    input  ptr_t  upd_val,
    output ptr_t  sp
);
    localparam int unsigned NHALF = PTR_W / BYTE_W;

    for (genvar g = 0; g < NHALF; g++) begin : g_half
        logic wen;
        assign wen = (g == 0) ? wr_lo : wr_hi;
        always_ff @(posedge clk) begin
            if (rst)
                sp[g*BYTE_W +: BYTE_W] <= '0;
            else if (wen)
                sp[g*BYTE_W +: BYTE_W] <= wr_data;
            else if (upd)
                sp[g*BYTE_W +: BYTE_W] <= upd_val[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import sp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [PTR_W-1:0]  sp_o,
    output logic [PTR_W-1:0]  addr_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic              lane_hi_o,
    output logic              busy_o
);
    op_e  op;
    logic busy, is_save, upd;
    ptr_t sp, upd_val;
    acc_t acc;

    sp_op_decode u_dec (
        .push(push_i), .pop(pop_i), .call(call_i), .ret(ret_i),
        .busy(busy), .wr_any(wr_hi_i | wr_lo_i), .op(op)
    );

    sp_seq u_seq (
        .clk(clk), .rst(rst), .op(op), .busy(busy), .is_save(is_save)
    );

    sp_addr_gen u_agen (
        .op(op), .busy(busy), .is_save(is_save), .sp(sp),
        .acc(acc), .upd(upd), .upd_val(upd_val)
    );

    sp_ptr_reg u_reg (
        .clk(clk), .rst(rst), .wr_hi(wr_hi_i), .wr_lo(wr_lo_i),
        .wr_data(wr_data_i), .upd(upd), .upd_val(upd_val), .sp(sp)
    );

    assign sp_o      = sp;
    assign addr_o    = acc.addr;
    assign mem_we_o  = acc.we;
    assign mem_re_o  = acc.re;
    assign lane_hi_o = acc.lane_hi;
    assign busy_o    = busy;
endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
    parameter int unsigned BW = 8,
    parameter int unsigned PW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          push_i,
    input logic          pop_i,
    input logic          call_i,
    input logic          ret_i,
    input logic          wr_hi_i,
    input logic          wr_lo_i,
    input logic [BW-1:0] wr_data_i,
    input logic [PW-1:0] sp_o,
    input logic          mem_we_o,
    input logic          mem_re_o,
    input logic          lane_hi_o,
    input logic          busy_o
);
    logic idle_nw;
    assign idle_nw = !busy_o && !wr_hi_i && !wr_lo_i;

    // R11
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we_o && mem_re_o));

    // R7
    two_beat_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);

    // R4
    call_beat1_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_nw && call_i) |=> (busy_o && mem_we_o && lane_hi_o));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_nw && push_i && !call_i && !ret_i)
        |=> sp_o == PW'($past(sp_o) - PW'(1)));

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (rst)
        (idle_nw && pop_i && !push_i && !call_i && !ret_i)
        |=> sp_o == PW'($past(sp_o) + PW'(1)));

    // R4
    save_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mem_we_o && !wr_hi_i && !wr_lo_i)
        |=> sp_o == PW'($past(sp_o) - PW'(2)));

    // R5
    restore_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mem_re_o && !wr_hi_i && !wr_lo_i)
        |=> sp_o == PW'($past(sp_o) + PW'(2)));

    // R9
    wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (wr_hi_i || wr_lo_i)) |-> (!mem_we_o && !mem_re_o));

    // R8
    wr_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lo_i && !wr_hi_i && !busy_o)
        |=> (sp_o[BW-1:0] == $past(wr_data_i) && sp_o[PW-1:BW] == $past(sp_o[PW-1:BW])));
endmodule

bind stack_ptr_unit sp_chk #(.BW(sp_pkg::BYTE_W), .PW(sp_pkg::PTR_W)) u_sp_chk (
    .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
    .ret_i(ret_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i),
    .sp_o(sp_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .lane_hi_o(lane_hi_o), .busy_o(busy_o)
);

// File: tb/test_stack_ptr_unit.sv
`timescale 1ns/1ps
module test_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        push_i, pop_i, call_i, ret_i, wr_hi_i, wr_lo_i;
    logic [7:0]  wr_data_i;
    logic [15:0] sp_o, addr_o;
    logic        mem_we_o, mem_re_o, lane_hi_o, busy_o;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [15:0] m_sp;
    bit          m_busy, m_save;

    always #2 clk = ~clk;

    stack_ptr_unit i_stack_ptr_unit (
        .clk(clk), .rst(rst), .push_i(push_i), .pop_i(pop_i), .call_i(call_i),
        .ret_i(ret_i), .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i),
        .sp_o(sp_o), .addr_o(addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .lane_hi_o(lane_hi_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] f_step(logic [15:0] p, bit down, bit two);
        logic [15:0] d;
        d = two ? 16'd2 : 16'd1;
        return down ? 16'(p - d) : 16'(p + d);
    endfunction

    // one clock cycle: drive, compare accesses, clock, compare pointer
    task automatic cyc(input bit pu, input bit po, input bit ca, input bit re,
                       input bit wh, input bit wl, input logic [7:0] d,
                       input string tag);
        logic [15:0] e_addr, e_nxt;
        bit e_we, e_re, e_lane, n_busy, n_save, stepped;
        @(negedge clk);
        push_i = pu; pop_i = po; call_i = ca; ret_i = re;
        wr_hi_i = wh; wr_lo_i = wl; wr_data_i = d;
        #1;
        e_addr = m_sp; e_we = 0; e_re = 0; e_lane = 0;
        e_nxt = m_sp; n_busy = 0; n_save = 0; stepped = 0;
        if (m_busy) begin
            stepped = 1;
            e_nxt = f_step(m_sp, m_save, 1);
            if (m_save) begin
                e_addr = f_step(m_sp, 1, 0); e_we = 1; e_lane = 1;
            end else begin
                e_addr = f_step(m_sp, 0, 1); e_re = 1;
            end
        end else if (!(wh || wl)) begin
            if (ca) begin
                e_we = 1; n_busy = 1; n_save = 1;
            end else if (re) begin
                e_addr = f_step(m_sp, 0, 0); e_re = 1; e_lane = 1; n_busy = 1;
            end else if (pu) begin
                e_we = 1; e_nxt = f_step(m_sp, 1, 0);
            end else if (po) begin
                e_addr = f_step(m_sp, 0, 0); e_re = 1; e_nxt = e_addr;
            end
        end
        if (wh) e_nxt[15:8] = d;
        if (wl) e_nxt[7:0]  = d;
        chk(busy_o == m_busy, tag, "busy", 32'(busy_o), 32'(m_busy));
        chk(mem_we_o == e_we && mem_re_o == e_re, tag, "we/re",
            {30'd0, mem_we_o, mem_re_o}, {30'd0, e_we, e_re});
        chk(lane_hi_o == e_lane, tag, "lane", 32'(lane_hi_o), 32'(e_lane));
        if (e_we || e_re)
            chk(addr_o == e_addr, tag, "addr", 32'(addr_o), 32'(e_addr));
        else
            chk(addr_o == m_sp, tag, "idle addr", 32'(addr_o), 32'(m_sp));
        @(posedge clk);
        #1;
        m_sp = e_nxt; m_busy = n_busy; m_save = n_save;
        chk(sp_o == m_sp, tag, "sp", 32'(sp_o), 32'(m_sp));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5A17);
        push_i = 0; pop_i = 0; call_i = 0; ret_i = 0;
        wr_hi_i = 0; wr_lo_i = 0; wr_data_i = 8'h00;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_sp = 16'h0000; m_busy = 0; m_save = 0;
        // R1 reset state
        chk(sp_o == 16'h0000, "R1", "sp", 32'(sp_o), 32'h0);
        chk(!busy_o && !mem_we_o && !mem_re_o, "R1", "idle",
            {29'd0, busy_o, mem_we_o, mem_re_o}, 32'h0);
        cyc(0,0,0,0,0,0,8'h00, "R11");
        // R8 half writes
        cyc(0,0,0,0,1,0,8'h08, "R8");
        cyc(0,0,0,0,0,1,8'h5F, "R8");
        cyc(0,0,0,0,0,0,8'h00, "R11");
        // R2 / R3 single byte
        cyc(1,0,0,0,0,0,8'h00, "R2");
        cyc(1,0,0,0,0,0,8'h00, "R2");
        cyc(0,1,0,0,0,0,8'h00, "R3");
        cyc(0,1,0,0,0,0,8'h00, "R3");
        // R4 / R5 two beats
        cyc(0,0,1,0,0,0,8'h00, "R4");
        cyc(0,0,0,0,0,0,8'h00, "R4");
        cyc(0,0,0,1,0,0,8'h00, "R5");
        cyc(0,0,0,0,0,0,8'h00, "R5");
        // R6 precedence
        cyc(1,1,1,1,0,0,8'h00, "R6");
        cyc(0,0,0,0,0,0,8'h00, "R6");
        cyc(1,1,0,1,0,0,8'h00, "R6");
        cyc(0,0,0,0,0,0,8'h00, "R6");
        cyc(1,1,0,0,0,0,8'h00, "R6");
        // R7 strobes in beat 1
        cyc(0,0,1,0,0,0,8'h00, "R7");
        cyc(1,1,1,1,0,0,8'h00, "R7");
        cyc(0,0,0,0,0,0,8'h00, "R7");
        // R9 write priority
        cyc(1,0,0,0,0,1,8'h40, "R9");
        cyc(0,0,1,0,0,0,8'h00, "R9");
        cyc(0,0,0,0,1,0,8'h07, "R9");
        cyc(0,0,0,1,1,1,8'h33, "R9");
        cyc(0,0,0,0,1,1,8'h00, "R8");
        // R10 wrap
        cyc(1,0,0,0,0,0,8'h00, "R10");
        cyc(0,1,0,0,0,0,8'h00, "R10");
        cyc(0,0,1,0,0,0,8'h00, "R10");
        cyc(0,0,0,0,0,0,8'h00, "R10");
        cyc(0,0,0,1,0,0,8'h00, "R10");
        cyc(0,0,0,0,0,0,8'h00, "R10");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  s;
            logic [2:0]  w;
            logic [7:0]  d;
            string       t;
            s = 4'($urandom);
            w = 3'($urandom);
            d = 8'($urandom);
            if (m_busy)                t = (s != 0) ? "R7" : (m_save ? "R4" : "R5");
            else if (w == 3'd0 || w == 3'd1) t = "R9";
            else if ($countones(s) > 1) t = "R6";
            else if (s[2])             t = "R4";
            else if (s[3])             t = "R5";
            else if (s[0])             t = "R2";
            else if (s[1])             t = "R3";
            else                       t = "R11";
            cyc(s[0], s[1], s[2], s[3], w == 3'd0, w == 3'd1 || w == 3'd0 && d[0], d, t);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule